// File: doc/BRIEF.md
# Wake-Up and Duty-Cycle Timer

This block raises wake-up events for a low-power radio controller. It counts strobes from a slow time base of about one millisecond. The wake-up interval is a mantissa shifted left by an exponent, so short intervals and very long intervals share one small counter. When the interval expires, the block emits a one-cycle wake pulse. It also sets a sticky status flag and drives an active-low interrupt request. Both stay asserted until a status read is acknowledged.

The timer is one-shot. Firmware clears the wake enable and sets it again to start the next interval. An optional low-duty-cycle mode opens a receiver-enable window at each wake event. The window lasts twice the duty value plus one ticks. The command words arrive already decoded from the serial interface, which lies outside this block, and are presented as plain register inputs.

Top module: `wake_duty_timer`

## Requirements
- R1: After reset, wake_pulse is 0, wake_flag is 0, irq_n is 1 and rx_win is 0.
- R2: After wake_en rises, the block counts tick strobes. The tick that completes M·2^R of them, counted after the arming cycle, makes wake_pulse high for exactly one clock cycle, in the cycle after that tick is sampled.
- R3: After one expiry, no further wake_pulse appears while wake_en stays high, however many ticks arrive.
- R4: While wake_en is low the count is cleared and no wake_pulse is produced. A new rising edge of wake_en restarts the count from zero.
- R5: When the mantissa field is 0, no wake_pulse is ever produced.
- R6: wake_flag goes high in the same cycle as wake_pulse and only then. irq_n is low exactly while wake_flag is high.
- R7: Asserting stat_ack for one cycle clears wake_flag and releases irq_n. If an expiry happens in the same cycle, the set wins and the flag stays high.
- R8: When ldc_cmd bit 0 is 1, rx_win rises together with wake_pulse. It then stays high until 2·D+1 more ticks have been sampled, where D is ldc_cmd bits 7..1.
- R9: When ldc_cmd bit 0 is 0, rx_win stays low. Clearing that bit during an open window closes it on the next cycle.
- R10: wkup_cmd carries R in bits 12..8 and M in bits 7..0. Bits 15..13 are ignored. The word E196h gives an interval of 300 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the ~1 ms time base |
| wake_en | input | 1 | Wake timer enable; a rising edge arms one interval |
| wkup_cmd | input | 16 | Interval command: R in bits 12..8, M in bits 7..0 |
| ldc_cmd | input | 8 | Duty command: D in bits 7..1, mode enable in bit 0 |
| stat_ack | input | 1 | Status-read acknowledge; clears the sticky flag |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_flag | output | 1 | Sticky wake-overflow status |
| irq_n | output | 1 | Active-low interrupt request |
| rx_win | output | 1 | Receiver-enable window in duty-cycle mode |

## Verification
The bench probes three kinds of counting error.

- Off-by-one errors: a design that counted the arming cycle's tick, or compared against M·2^R−1, would fire one tick early.
- Re-arming errors: a free-running timer would fire again after the first expiry. A design that kept its count across a disable would fire too soon after re-enable.
- Zero mantissa: a design that did not block a zero mantissa would wake on the first tick.

The bench also drives an acknowledge into the same cycle as an expiry, where a clear-first design would lose the event. It times the receiver window to the exact tick on which it must close. It runs the power-on interval word, and the same word with its prefix bits changed, to show the field positions are decoded correctly.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
   // Counter width able to hold mant << exp for every legal exponent.
   function automatic int period_width(input int mant_w, input int exp_w);
      return mant_w + (1 << exp_w) - 1;
   endfunction
   localparam int PREFIX_W = 3;
endpackage

// File: rtl/wkt_period.sv
module wkt_period #(
   parameter int EXP_W      = 5,
   parameter int MANT_W     = 8,
   parameter bit PERIOD_REG = 1'b0,
   localparam int CNT_W     = wkt_pkg::period_width(MANT_W, EXP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EXP_W-1:0]  exp_r,
   input  logic [MANT_W-1:0] mant_m,
   output logic [CNT_W-1:0]  period
);
   logic [CNT_W-1:0] shifted;
   assign shifted = CNT_W'(mant_m) << exp_r;

   generate
      if (PERIOD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) period <= '0;
            else        period <= shifted;
         end
      end else begin : g_comb
         assign period = shifted;
      end
   endgenerate
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
   parameter int CNT_W = 39
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic [CNT_W-1:0] period,
   output logic             expire_now,
   output logic             fire
);
   logic             en_q;
   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;
   logic             arm_rise;
   logic             live;

   assign arm_rise   = run_en & ~en_q;
   assign cnt_nx     = cnt + CNT_W'(1);
   assign live       = run_en & ~arm_rise & armed & tick & (period != '0);
   assign expire_now = live & (cnt_nx >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         armed <= 1'b0;
         cnt   <= '0;
         fire  <= 1'b0;
      end else begin
         en_q <= run_en;
         fire <= expire_now;
         if (!run_en) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (arm_rise) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (expire_now) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (live) begin
            cnt <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/wkt_window.sv
module wkt_window #(
   parameter int DUTY_W = 7,
   localparam int WIN_W = DUTY_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode_en,
   input  logic [DUTY_W-1:0] duty_d,
   input  logic              load,
   output logic              rx_win
);
   logic [WIN_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      left <= '0;
      else if (!mode_en)               left <= '0;
      else if (load)                   left <= {duty_d, 1'b1};
      else if (tick && left != '0)     left <= left - WIN_W'(1);
   end

   assign rx_win = (left != '0);
endmodule

// File: rtl/wkt_status.sv
module wkt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/wake_duty_timer.sv
module wake_duty_timer #(
   parameter int EXP_W      = 5,
   parameter int MANT_W     = 8,
   parameter int DUTY_W     = 7,
   parameter bit PERIOD_REG = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic                      wake_en,
   input  logic [EXP_W+MANT_W+2:0]   wkup_cmd,
   input  logic [DUTY_W:0]           ldc_cmd,
   input  logic                      stat_ack,
   output logic                      wake_pulse,
   output logic                      wake_flag,
   output logic                      irq_n,
   output logic                      rx_win
);
   localparam int CNT_W = wkt_pkg::period_width(MANT_W, EXP_W);

   generate
      if (EXP_W < 1 || EXP_W > 6) begin : g_bad_exp
         $error("EXP_W must lie in 1..6");
      end
      if (MANT_W < 1 || DUTY_W < 1) begin : g_bad_width
         $error("MANT_W and DUTY_W must be positive");
      end
   endgenerate

   logic [EXP_W-1:0]  exp_r;
   logic [MANT_W-1:0] mant_m;
   logic [CNT_W-1:0]  period;
   logic              expire_now;

   assign mant_m = wkup_cmd[MANT_W-1:0];
   assign exp_r  = wkup_cmd[MANT_W +: EXP_W];

   wkt_period #(.EXP_W(EXP_W), .MANT_W(MANT_W), .PERIOD_REG(PERIOD_REG)) u_period (
      .clk(clk), .rst_n(rst_n), .exp_r(exp_r), .mant_m(mant_m), .period(period));

   wkt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(wake_en), .period(period),
      .expire_now(expire_now), .fire(wake_pulse));

   wkt_window #(.DUTY_W(DUTY_W)) u_window (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_en(ldc_cmd[0]),
      .duty_d(ldc_cmd[DUTY_W:1]), .load(expire_now), .rx_win(rx_win));

   wkt_status u_status (
      .clk(clk), .rst_n(rst_n), .set(expire_now), .clr(stat_ack), .flag(wake_flag));

   assign irq_n = ~wake_flag;
endmodule

// File: rtl/wake_duty_timer_chk.sv
module wake_duty_timer_chk #(
   parameter int EXP_W  = 5,
   parameter int MANT_W = 8,
   parameter int DUTY_W = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wake_en,
   input logic [EXP_W+MANT_W+2:0] wkup_cmd,
   input logic [DUTY_W:0]         ldc_cmd,
   input logic                    stat_ack,
   input logic                    wake_pulse,
   input logic                    wake_flag,
   input logic                    rx_win
);
   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_en |=> !wake_pulse);

   assert_zero_mant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wkup_cmd[MANT_W-1:0] == '0) |=> !wake_pulse);

   assert_flag_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> wake_flag);

   assert_flag_rise_only_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> wake_pulse);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ack |=> (!wake_flag || wake_pulse));

   assert_win_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && $past(ldc_cmd[0])) |-> rx_win);

   assert_win_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ldc_cmd[0] |=> !rx_win);
endmodule

bind wake_duty_timer wake_duty_timer_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W), .DUTY_W(DUTY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .wkup_cmd(wkup_cmd), .ldc_cmd(ldc_cmd),
   .stat_ack(stat_ack), .wake_pulse(wake_pulse), .wake_flag(wake_flag), .rx_win(rx_win));

// File: tb/wake_duty_timer_bench.sv
module wake_duty_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wake_en = 1'b0;
   logic [15:0] wkup_cmd = 16'h0;
   logic [7:0]  ldc_cmd = 8'h0;
   logic        stat_ack = 1'b0;
   logic        wake_pulse, wake_flag, irq_n, rx_win;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   localparam int S_PULSE = 0, S_FLAG = 1, S_IRQ = 2, S_WIN = 3;
   typedef struct { string req; int sel; logic val; } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   wake_duty_timer u_wake_duty_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wake_en(wake_en), .wkup_cmd(wkup_cmd),
      .ldc_cmd(ldc_cmd), .stat_ack(stat_ack), .wake_pulse(wake_pulse),
      .wake_flag(wake_flag), .irq_n(irq_n), .rx_win(rx_win));

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic  act;
         it = sb.pop_front();
         case (it.sel)
            S_PULSE: act = wake_pulse;
            S_FLAG:  act = wake_flag;
            S_IRQ:   act = irq_n;
            default: act = rx_win;
         endcase
         checks++;
         if (act !== it.val) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.val);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000 && !done) begin
         fails++;
         $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic clk1();
      @(posedge clk); #1;
   endtask
   task automatic tk();
      tick = 1'b1; clk1(); tick = 1'b0;
   endtask
   task automatic tks(input int n);
      for (int i = 0; i < n; i++) tk();
   endtask
   task automatic rearm();
      wake_en = 1'b0; clk1(); wake_en = 1'b1; clk1(); clk1();
   endtask
   task automatic ack();
      stat_ack = 1'b1; clk1(); stat_ack = 1'b0;
   endtask
   task automatic exp_sig(input string req, input int sel, input logic val);
      sb.push_back('{req, sel, val});
   endtask
   function automatic logic [15:0] word(input int r, input int m);
      return {3'b111, 5'(r), 8'(m)};
   endfunction

   initial begin
      clk1(); clk1();
      rst_n = 1'b1;
      clk1();
      exp_sig("R1", S_PULSE, 1'b0); exp_sig("R1", S_FLAG, 1'b0);
      exp_sig("R1", S_IRQ, 1'b1);   exp_sig("R1", S_WIN, 1'b0);

      // R2: 1 << 2 = 4 ticks
      wkup_cmd = word(2, 1);
      rearm();
      for (int i = 0; i < 3; i++) begin tk(); exp_sig("R2", S_PULSE, 1'b0); end
      tk();
      exp_sig("R2", S_PULSE, 1'b1); exp_sig("R6", S_FLAG, 1'b1); exp_sig("R6", S_IRQ, 1'b0);
      clk1();
      exp_sig("R2", S_PULSE, 1'b0); exp_sig("R6", S_FLAG, 1'b1);

      // R3: one-shot
      for (int i = 0; i < 6; i++) begin tk(); exp_sig("R3", S_PULSE, 1'b0); end

      // R7: acknowledge clears
      ack();
      exp_sig("R7", S_FLAG, 1'b0); exp_sig("R7", S_IRQ, 1'b1);

      // R4: disable clears count; 3 << 1 = 6 ticks
      wkup_cmd = word(1, 3);
      rearm();
      tks(3);
      wake_en = 1'b0; clk1();
      tk(); exp_sig("R4", S_PULSE, 1'b0);
      tk(); exp_sig("R4", S_PULSE, 1'b0);
      wake_en = 1'b1; clk1();
      tks(5); exp_sig("R4", S_FLAG, 1'b0);
      tk();   exp_sig("R4", S_PULSE, 1'b1);
      ack();

      // R7: set wins over a simultaneous acknowledge
      rearm();
      tks(5);
      stat_ack = 1'b1; tk(); stat_ack = 1'b0;
      exp_sig("R7", S_FLAG, 1'b1); exp_sig("R7", S_IRQ, 1'b0);
      ack();

      // R5: zero mantissa never wakes
      wkup_cmd = word(3, 0);
      rearm();
      for (int i = 0; i < 20; i++) begin tk(); exp_sig("R5", S_PULSE, 1'b0); end
      exp_sig("R5", S_FLAG, 1'b0);

      // R8: window of 2*2+1 = 5 ticks, period 2 << 3 = 16
      ldc_cmd  = {7'd2, 1'b1};
      wkup_cmd = word(3, 2);
      rearm();
      tks(15); exp_sig("R8", S_WIN, 1'b0); exp_sig("R8", S_PULSE, 1'b0);
      tk();    exp_sig("R8", S_PULSE, 1'b1); exp_sig("R8", S_WIN, 1'b1);
      tks(4);  exp_sig("R8", S_WIN, 1'b1);
      tk();    exp_sig("R8", S_WIN, 1'b0);
      ack();

      // R9: mode off keeps window shut; clearing it closes an open window
      ldc_cmd = {7'd2, 1'b0};
      rearm();
      tks(16); exp_sig("R9", S_PULSE, 1'b1); exp_sig("R9", S_WIN, 1'b0);
      ack();
      ldc_cmd = {7'd2, 1'b1};
      rearm();
      tks(16); exp_sig("R9", S_WIN, 1'b1);
      ldc_cmd[0] = 1'b0; clk1();
      exp_sig("R9", S_WIN, 1'b0);
      ack();

      // R10: power-on word and ignored prefix bits, 150 << 1 = 300
      wkup_cmd = 16'hE196;
      rearm();
      tks(299); exp_sig("R10", S_FLAG, 1'b0);
      tk();     exp_sig("R10", S_PULSE, 1'b1);
      ack();
      wkup_cmd = 16'h0196;
      rearm();
      tks(299); exp_sig("R10", S_FLAG, 1'b0);
      tk();     exp_sig("R10", S_PULSE, 1'b1);

      clk1(); clk1();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule